// File: doc/BRIEF.md
# Data Access Breakpoint and Alignment Guard

This block sits in the load/store path and looks at every data access before it is allowed to reach memory. Each access presents a 32-bit address, a store/load flag and a valid strobe. The block first applies an optional process-ID relocation to addresses in the lowest 32 MiB window. It then checks word alignment when alignment checking is enabled, and finally compares the address against two programmable data breakpoints. All results appear one clock after the access: the relocated address, a data-abort request with latched fault status and fault address, and a single-cycle breakpoint pulse.

A small write-only configuration port loads the relocation register, the alignment enable, the two breakpoint registers, the breakpoint control word and the debug status word. The debug status word is visible on an output port. When a breakpoint fires, the block records a method-of-entry code in that word. When the word shows that the debug monitor is already active, breakpoint checking is switched off. Vectoring to the abort handler and running the debug monitor are left to the surrounding core.

Top module: `dbrk_align_guard`

## Requirements
- R1: When bits [31:25] of the relocation register are nonzero and bits [31:25] of the access address are all zero, those relocation bits are ORed into the address. Otherwise the address passes unchanged. The result appears on `addr_o` with `addr_vld_o` one cycle after the access.
- R2: When alignment checking is enabled (control register bit 0 = 1) and address bits [1:0] are nonzero, `abort_o` is high one cycle after the access. In the same cycle `fsr_o` holds the alignment code 0x01 and `far_o` holds the relocated address. With checking disabled, a misaligned access raises no abort.
- R3: Each 2-bit breakpoint enable is decoded as follows: 0 = disabled, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R4: The enable for breakpoint 0 sits in breakpoint-control bits [1:0]. The enable for breakpoint 1 sits in bits [3:2].
- R5: When breakpoint-control bit 8 is 1 (mask mode), breakpoint register 1 is a bit mask. An access hits when (addr & ~mask) == (bp0 & ~mask), gated by enable 0 only. Enable 1 then has no effect.
- R6: When bit 8 is 0, each breakpoint compares address bits [31:2] against its own register, gated by its own enable. Address bits [1:0] are ignored.
- R7: While debug status bit 31 is 1, no access produces a breakpoint hit, and the debug status word is left unchanged.
- R8: On a hit, `bp_hit_o` is high for one cycle, one cycle after the access. At the same edge, debug status bits [4:2] become 3'b010 and all other status bits are kept.
- R9: An access that matches both breakpoints produces one single-cycle `bp_hit_o` pulse.
- R10: An access that raises an alignment abort produces no breakpoint hit and leaves the debug status word unchanged.
- R11: Configuration writes (select 0 relocation, 1 control, 2 bp0, 3 bp1, 4 breakpoint control, 5 debug status) take effect at the clock edge. An access in the same cycle uses the old values. All registers reset to zero. Without a valid access, neither `abort_o` nor `bp_hit_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Access address |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| addr_o | output | 32 | Relocated address, registered |
| addr_vld_o | output | 1 | Registered access strobe |
| abort_o | output | 1 | Data-abort request, one cycle |
| fsr_o | output | 8 | Fault status, latched on abort |
| far_o | output | 32 | Fault address, latched on abort |
| bp_hit_o | output | 1 | Breakpoint hit pulse |
| dstat_o | output | 32 | Debug status word |

## Verification
The assertions are checked on every cycle. They check the following: an abort always comes with the alignment code and a misaligned fault address; an abort and a breakpoint pulse never occur together; an active monitor bit always blocks a hit; every hit leaves the method-of-entry code in the status word; and idle cycles stay quiet. Other behaviours need chosen stimulus from the bench's scenarios. These are the exact enable decode for stores versus loads, the placement of the two enable fields, the mask arithmetic, the word-granular comparison, the preservation of the other status bits, and the relocation values.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned RELOC_W = 7;
  localparam int unsigned EN_W    = 2;
  localparam int unsigned MOE_W   = 3;
  localparam int unsigned MOE_LSB = 2;
  localparam int unsigned FSR_W   = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned N_BRK   = 2;
  localparam int unsigned MON_BIT = ADDR_W - 1;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOC = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_BRK0  = 3'd2,
    SEL_BRK1  = 3'd3,
    SEL_BCTL  = 3'd4,
    SEL_DSTAT = 3'd5
  } cfg_sel_e;

  // Relocate addresses of the lowest window by the process ID bits.
  function automatic addr_t reloc_apply(input addr_t a, input logic [RELOC_W-1:0] pid);
    addr_t r;
    r = a;
    if (pid != '0 && a[ADDR_W-1 -: RELOC_W] == '0)
      r = a | {pid, {(ADDR_W-RELOC_W){1'b0}}};
    return r;
  endfunction

  // Direction filter of one breakpoint enable field.
  function automatic logic en_allows(input logic [EN_W-1:0] en, input logic is_store);
    logic ok;
    if (en == 2'd0)   ok = 1'b0;
    else if (is_store) ok = (en != 2'd3);
    else               ok = (en != 2'd1);
    return ok;
  endfunction

  function automatic logic word_eq(input addr_t a, input addr_t b);
    return a[ADDR_W-1:2] == b[ADDR_W-1:2];
  endfunction

  function automatic logic mask_eq(input addr_t a, input addr_t r0, input addr_t m);
    return ((a ^ r0) & ~m) == '0;
  endfunction
endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs
  import guard_pkg::*;
#(
  parameter logic [MOE_W-1:0] MOE_CODE = 3'b010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  addr_t              cfg_wdata,
  input  logic               hit_evt,
  output logic [RELOC_W-1:0] reloc_pid,
  output logic               align_en,
  output addr_t              brk0,
  output addr_t              brk1,
  output addr_t              bctl,
  output addr_t              dstat
);
  logic dstat_wr;
  assign dstat_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_DSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_pid <= '0;
      align_en  <= 1'b0;
      brk0      <= '0;
      brk1      <= '0;
      bctl      <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_RELOC: reloc_pid <= cfg_wdata[ADDR_W-1 -: RELOC_W];
        SEL_CTRL:  align_en  <= cfg_wdata[0];
        SEL_BRK0:  brk0      <= cfg_wdata;
        SEL_BRK1:  brk1      <= cfg_wdata;
        SEL_BCTL:  bctl      <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dstat <= '0;
    else if (dstat_wr)
      dstat <= cfg_wdata;
    else if (hit_evt)
      dstat[MOE_LSB +: MOE_W] <= MOE_CODE;
  end
endmodule

// File: rtl/guard_reloc_align.sv
module guard_reloc_align
  import guard_pkg::*;
(
  input  logic               acc_valid,
  input  addr_t              addr_in,
  input  logic [RELOC_W-1:0] reloc_pid,
  input  logic               align_en,
  output addr_t              addr_rel,
  output logic               align_flt
);
  assign addr_rel  = reloc_apply(addr_in, reloc_pid);
  assign align_flt = acc_valid && align_en && (addr_rel[1:0] != 2'b00);
endmodule

// File: rtl/guard_brk_match.sv
module guard_brk_match
  import guard_pkg::*;
#(
  parameter int unsigned MASK_BIT = 8
) (
  input  logic  acc_valid,
  input  addr_t addr,
  input  logic  is_store,
  input  addr_t brk0,
  input  addr_t brk1,
  input  addr_t bctl,
  input  logic  suppress,
  output logic  hit0,
  output logic  hit1,
  output logic  hit_any
);
  logic          mask_mode;
  logic          live;
  addr_t         brk_reg [N_BRK];
  logic [N_BRK-1:0] raw;

  assign mask_mode  = bctl[MASK_BIT];
  assign live       = acc_valid && !suppress;
  assign brk_reg[0] = brk0;
  assign brk_reg[1] = brk1;

  for (genvar k = 0; k < N_BRK; k++) begin : g_cmp
    logic           dir_ok;
    logic           addr_ok;
    assign dir_ok = en_allows(bctl[k*EN_W +: EN_W], is_store);
    if (k == 0) begin : g_first
      assign addr_ok = mask_mode ? mask_eq(addr, brk0, brk1) : word_eq(addr, brk_reg[k]);
    end else begin : g_other
      assign addr_ok = !mask_mode && word_eq(addr, brk_reg[k]);
    end
    assign raw[k] = live && dir_ok && addr_ok;
  end

  assign hit0    = raw[0];
  assign hit1    = raw[1];
  assign hit_any = |raw;
endmodule

// File: rtl/dbrk_align_guard.sv
module dbrk_align_guard
  import guard_pkg::*;
#(
  parameter logic [FSR_W-1:0] FSR_ALIGN_CODE = 8'h01,
  parameter logic [MOE_W-1:0] MOE_DBRK       = 3'b010,
  parameter int unsigned      MASK_BIT       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [31:0]       acc_addr_i,
  input  logic              acc_store_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       addr_o,
  output logic              addr_vld_o,
  output logic              abort_o,
  output logic [7:0]        fsr_o,
  output logic [31:0]       far_o,
  output logic              bp_hit_o,
  output logic [31:0]       dstat_o
);
  logic [RELOC_W-1:0] reloc_pid;
  logic               align_en;
  addr_t              brk0, brk1, bctl, dstat;
  addr_t              addr_rel;
  logic               chk_align_flt;
  logic               chk_hit0, chk_hit1, chk_any_hit;
  logic               chk_suppress;

  guard_cfg_regs #(.MOE_CODE(MOE_DBRK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we_i),
    .cfg_sel   (cfg_sel_i),
    .cfg_wdata (cfg_wdata_i),
    .hit_evt   (chk_any_hit),
    .reloc_pid (reloc_pid),
    .align_en  (align_en),
    .brk0      (brk0),
    .brk1      (brk1),
    .bctl      (bctl),
    .dstat     (dstat)
  );

  guard_reloc_align u_ra (
    .acc_valid (acc_valid_i),
    .addr_in   (acc_addr_i),
    .reloc_pid (reloc_pid),
    .align_en  (align_en),
    .addr_rel  (addr_rel),
    .align_flt (chk_align_flt)
  );

  assign chk_suppress = dstat[MON_BIT] || chk_align_flt;

  guard_brk_match #(.MASK_BIT(MASK_BIT)) u_bm (
    .acc_valid (acc_valid_i),
    .addr      (addr_rel),
    .is_store  (acc_store_i),
    .brk0      (brk0),
    .brk1      (brk1),
    .bctl      (bctl),
    .suppress  (chk_suppress),
    .hit0      (chk_hit0),
    .hit1      (chk_hit1),
    .hit_any   (chk_any_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      abort_o    <= 1'b0;
      bp_hit_o   <= 1'b0;
      fsr_o      <= '0;
      far_o      <= '0;
    end else begin
      addr_vld_o <= acc_valid_i;
      abort_o    <= chk_align_flt;
      bp_hit_o   <= chk_any_hit;
      if (acc_valid_i) addr_o <= addr_rel;
      if (chk_align_flt) begin
        fsr_o <= FSR_ALIGN_CODE;
        far_o <= addr_rel;
      end
    end
  end

  assign dstat_o = dstat;
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter logic [7:0] FSR_CODE = 8'h01,
  parameter logic [2:0] MOE_CODE = 3'b010
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid_i,
  input logic        cfg_we_i,
  input logic [2:0]  cfg_sel_i,
  input logic        abort_o,
  input logic [7:0]  fsr_o,
  input logic [31:0] far_o,
  input logic        bp_hit_o,
  input logic [31:0] dstat_o,
  input logic [31:0] addr_o,
  input logic [6:0]  reloc_pid,
  input logic        align_en,
  input logic        chk_hit0,
  input logic        chk_hit1,
  input logic        chk_any_hit
);
  AST_ABORT_FSR: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> fsr_o == FSR_CODE); // R2
  AST_ABORT_FAR_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> far_o[1:0] != 2'b00); // R2
  AST_ALIGN_OFF_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !align_en) |=> !abort_o); // R2
  AST_RELOC_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && reloc_pid != 7'd0) |=> addr_o[31:25] != 7'd0); // R1
  AST_MONITOR_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && dstat_o[31]) |=> !bp_hit_o); // R7
  AST_HIT_MOE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_any_hit && !(cfg_we_i && cfg_sel_i == 3'd5)) |=> dstat_o[4:2] == MOE_CODE); // R8
  AST_DUAL_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit0 && chk_hit1) |=> bp_hit_o); // R9
  AST_ABORT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && bp_hit_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !(abort_o || bp_hit_o)); // R11
endmodule

bind dbrk_align_guard guard_chk #(.FSR_CODE(FSR_ALIGN_CODE), .MOE_CODE(MOE_DBRK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_sel_i   (cfg_sel_i),
  .abort_o     (abort_o),
  .fsr_o       (fsr_o),
  .far_o       (far_o),
  .bp_hit_o    (bp_hit_o),
  .dstat_o     (dstat_o),
  .addr_o      (addr_o),
  .reloc_pid   (reloc_pid),
  .align_en    (align_en),
  .chk_hit0    (chk_hit0),
  .chk_hit1    (chk_hit1),
  .chk_any_hit (chk_any_hit)
);

// File: tb/test_dbrk_align_guard.sv
module test_dbrk_align_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_store_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] addr_o, far_o, dstat_o;
  logic        addr_vld_o, abort_o, bp_hit_o;
  logic [7:0]  fsr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbrk_align_guard i_dbrk_align_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .acc_store_i(acc_store_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .addr_o(addr_o), .addr_vld_o(addr_vld_o),
    .abort_o(abort_o), .fsr_o(fsr_o), .far_o(far_o), .bp_hit_o(bp_hit_o),
    .dstat_o(dstat_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // Drive one access; returns at the next falling edge with outputs of that access.
  task automatic acc(input logic [31:0] a, input logic st);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_store_i = st;
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 reset addr_vld", {31'd0, addr_vld_o}, 32'd0);
    check("R11 reset abort", {31'd0, abort_o}, 32'd0);
    check("R11 reset hit", {31'd0, bp_hit_o}, 32'd0);
    check("R11 reset dstat", dstat_o, 32'd0);
    check("R11 reset fsr", {24'd0, fsr_o}, 32'd0);
  endtask

  task automatic t_reloc;
    cfg(3'd0, 32'h0A00_0000);
    acc(32'h0000_1234, 1'b0);
    check("R1 relocated", addr_o, 32'h0A00_1234);
    check("R1 vld", {31'd0, addr_vld_o}, 32'd1);
    acc(32'h4000_1234, 1'b0);
    check("R1 high addr kept", addr_o, 32'h4000_1234);
    cfg(3'd0, 32'h0);
    acc(32'h0000_5678, 1'b1);
    check("R1 zero pid", addr_o, 32'h0000_5678);
  endtask

  task automatic t_align;
    cfg(3'd1, 32'h1);
    acc(32'h0000_1002, 1'b0);
    check("R2 abort", {31'd0, abort_o}, 32'd1);
    check("R2 fsr", {24'd0, fsr_o}, 32'h01);
    check("R2 far", far_o, 32'h0000_1002);
    acc(32'h0000_1004, 1'b0);
    check("R2 aligned no abort", {31'd0, abort_o}, 32'd0);
    cfg(3'd1, 32'h0);
    acc(32'h0000_1003, 1'b1);
    check("R2 disabled no abort", {31'd0, abort_o}, 32'd0);
  endtask

  task automatic t_enables;
    cfg(3'd2, 32'h0000_2000);
    cfg(3'd3, 32'h0000_3000);
    cfg(3'd4, 32'h1);
    acc(32'h0000_2000, 1'b1);
    check("R3 en=1 store hits", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_2000, 1'b0);
    check("R3 en=1 load misses", {31'd0, bp_hit_o}, 32'd0);
    cfg(3'd4, 32'h3);
    acc(32'h0000_2000, 1'b0);
    check("R3 en=3 load hits", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_2000, 1'b1);
    check("R3 en=3 store misses", {31'd0, bp_hit_o}, 32'd0);
    cfg(3'd4, 32'h2);
    acc(32'h0000_2000, 1'b1);
    check("R3 en=2 store hits", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_2003, 1'b0);
    check("R6 en=2 load, low bits ignored", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_2004, 1'b0);
    check("R6 next word misses", {31'd0, bp_hit_o}, 32'd0);
    cfg(3'd4, 32'h0);
    acc(32'h0000_2000, 1'b1);
    check("R3 en=0 disabled", {31'd0, bp_hit_o}, 32'd0);
    cfg(3'd4, 32'h4);
    acc(32'h0000_3000, 1'b1);
    check("R4 en1 field store hits bp1", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_2000, 1'b1);
    check("R4 en1 does not gate bp0", {31'd0, bp_hit_o}, 32'd0);
  endtask

  task automatic t_mask;
    cfg(3'd2, 32'h0000_5000);
    cfg(3'd3, 32'h0000_00F0);
    cfg(3'd4, 32'h102);
    acc(32'h0000_50A0, 1'b0);
    check("R5 masked match", {31'd0, bp_hit_o}, 32'd1);
    acc(32'h0000_5100, 1'b0);
    check("R5 unmasked bit differs", {31'd0, bp_hit_o}, 32'd0);
    acc(32'h0000_5001, 1'b1);
    check("R5 low bits not masked", {31'd0, bp_hit_o}, 32'd0);
    cfg(3'd4, 32'h104);
    acc(32'h0000_5000, 1'b1);
    check("R5 en1 ignored in mask mode", {31'd0, bp_hit_o}, 32'd0);
    acc(32'h0000_00F0, 1'b1);
    check("R5 bp1 not compared", {31'd0, bp_hit_o}, 32'd0);
  endtask

  task automatic t_status;
    cfg(3'd2, 32'h0000_2000);
    cfg(3'd4, 32'h2);
    cfg(3'd5, 32'h8000_0000);
    acc(32'h0000_2000, 1'b1);
    check("R7 monitor skips hit", {31'd0, bp_hit_o}, 32'd0);
    check("R7 dstat unchanged", dstat_o, 32'h8000_0000);
    cfg(3'd5, 32'h0000_0063);
    acc(32'h0000_2000, 1'b0);
    check("R8 hit pulse", {31'd0, bp_hit_o}, 32'd1);
    check("R8 dstat moe", dstat_o, 32'h0000_006B);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, bp_hit_o}, 32'd0);
  endtask

  task automatic t_dual;
    cfg(3'd2, 32'h0000_2000);
    cfg(3'd3, 32'h0000_2000);
    cfg(3'd4, 32'hA);
    acc(32'h0000_2000, 1'b1);
    check("R9 dual hit pulse", {31'd0, bp_hit_o}, 32'd1);
    @(negedge clk);
    check("R9 single pulse", {31'd0, bp_hit_o}, 32'd0);
  endtask

  task automatic t_abort_wins;
    cfg(3'd5, 32'h0);
    cfg(3'd1, 32'h1);
    acc(32'h0000_2001, 1'b1);
    check("R10 abort raised", {31'd0, abort_o}, 32'd1);
    check("R10 no hit", {31'd0, bp_hit_o}, 32'd0);
    check("R10 dstat unchanged", dstat_o, 32'h0);
    cfg(3'd1, 32'h0);
  endtask

  task automatic t_same_cycle_cfg;
    cfg(3'd0, 32'h0);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd0; cfg_wdata_i = 32'h0600_0000;
    acc_valid_i = 1'b1; acc_addr_i = 32'h0000_0040; acc_store_i = 1'b0;
    @(negedge clk);
    cfg_we_i = 1'b0; acc_valid_i = 1'b0;
    check("R11 old cfg used", addr_o, 32'h0000_0040);
    acc(32'h0000_0040, 1'b0);
    check("R11 new cfg used", addr_o, 32'h0600_0040);
    @(negedge clk);
    check("R11 idle no hit", {31'd0, bp_hit_o}, 32'd0);
    check("R11 idle vld low", {31'd0, addr_vld_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reloc();
    t_align();
    t_enables();
    t_mask();
    t_status();
    t_dual();
    t_abort_wins();
    t_same_cycle_cfg();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule